// File: doc/BRIEF.md
# Done-Queue Burst Coalescing Stager

This block sits between a receive engine that produces one-word completion descriptors and the circular done queue that the host reads. With coalescing enabled, it stages descriptors in a small FIFO and does not touch the ring until the FIFO reaches a fixed high-water mark. At that point it compares the staged count with the free room in the ring and then emits one burst that carries as many descriptors as fit. The free room comes from the host's read pointer and the block's own write pointer. When the burst would run past the last ring slot, it is split into two bursts, and the second starts at slot zero.

A burst appears on the output as one beat per cycle with consecutive ring indices. The first beat of each burst carries a start marker and the burst length. When a burst segment finishes, the write pointer moves past it and a one-cycle done pulse is raised. When a write is due but the ring has no free slot, the block raises a one-cycle error pulse instead, writes nothing and leaves the pointer where it is. With coalescing disabled, every descriptor goes out on its own as a one-beat burst. The push side stalls while the FIFO is full, so no descriptor is lost.

Top module: `dqb_burst_stager`

## Requirements
- R1: After reset, wr_ptr is 0, bw_valid, bw_start, wr_done and wr_err are 0, and push_ready is 1.
- R2: While fifo_en is 1 and fewer than HWM (default 6) descriptors are held, no beat is emitted.
- R3: When a write is due, the burst carries min(held, room) descriptors, where room = (host_rd_ptr - wr_ptr - 1) mod queue_size (one slot always stays empty).
- R4: When a write is due and room is 0, wr_err pulses for one cycle, no beat is emitted in that cycle, and wr_ptr does not change.
- R5: In the cycle after the last beat of a segment, wr_ptr equals the slot after that beat (modulo queue_size) and wr_done is 1 for that one cycle. wr_ptr changes at no other time.
- R6: A burst that would pass slot queue_size-1 is split, and the second segment starts at slot 0 in the cycle right after the first segment's last beat.
- R7: While fifo_en is 0, a write is due as soon as one descriptor is held, and every burst has length 1.
- R8: push_ready is 0 exactly while DEPTH (default 8) descriptors are held. Descriptors leave on bw_data in the order they were accepted, and none is dropped.
- R9: A burst is a run of beats in back-to-back cycles with rising ring indices. bw_start is 1 only on the first beat, and bw_len (nonzero) is valid on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = coalesce up to the high-water mark, 0 = write each descriptor alone |
| push_valid | input | 1 | Descriptor offered |
| push_data | input | DESC_W | Descriptor word |
| push_ready | output | 1 | Descriptor accepted when push_valid and push_ready are both 1 |
| host_rd_ptr | input | PTR_W | Host read index into the ring |
| queue_size | input | PTR_W | Number of ring slots |
| bw_valid | output | 1 | One descriptor beat on the burst interface |
| bw_start | output | 1 | First beat of a burst |
| bw_addr | output | PTR_W | Ring index of this beat |
| bw_len | output | LEN_W | Burst length, valid with bw_start |
| bw_data | output | DESC_W | Descriptor carried by this beat |
| wr_ptr | output | PTR_W | Block's write index into the ring |
| wr_done | output | 1 | Pulse: a burst segment was committed |
| wr_err | output | 1 | Pulse: write due but the ring is full |

## Verification
The bound checker checks the following on every cycle: an error pulse never coincides with a beat or a pointer move; the pointer moves only with a done pulse; bursts consist of contiguous beats with rising indices; and a segment that directly follows another starts at slot zero. Some behaviour only the bench scenarios can show: the high-water threshold, clipping of the burst length to the ring room, full-FIFO stalling with ordered delivery, and the one-by-one path while coalescing is off. The bench shows these by comparing every output with a queue-based reference model on every cycle.

// File: rtl/dqb_pkg.sv
package dqb_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_BURST = 1'b1
   } dqb_state_e;
endpackage

// File: rtl/dqb_fifo.sv
module dqb_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] head, tail;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] i);
      return (i == AW'(DEPTH - 1)) ? '0 : i + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[tail] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= step(tail);
         if (pop)  head <= step(head);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[head];
   assign full = (count == CW'(DEPTH));
endmodule

// File: rtl/dqb_room.sv
module dqb_room #(
   parameter int PTR_W = 10
) (
   input  logic [PTR_W-1:0] wr_idx,
   input  logic [PTR_W-1:0] rd_idx,
   input  logic [PTR_W-1:0] size,
   output logic [PTR_W-1:0] room
);
   logic [PTR_W:0] diff;

   always_comb begin
      if (rd_idx > wr_idx)
         diff = {1'b0, rd_idx} - {1'b0, wr_idx} - 1'b1;
      else
         diff = {1'b0, size} - {1'b0, wr_idx} + {1'b0, rd_idx} - 1'b1;
   end

   assign room = diff[PTR_W-1:0];
endmodule

// File: rtl/dqb_ctrl.sv
module dqb_ctrl
   import dqb_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int HWM   = 6,
   parameter int PTR_W = 10,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int XW   = ((PTR_W > CW) ? PTR_W : CW) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CW-1:0]    count,
   input  logic [PTR_W-1:0] room,
   input  logic [PTR_W-1:0] size,
   output logic             pop,
   output logic             beat,
   output logic             first_beat,
   output logic [PTR_W-1:0] addr,
   output logic [CW-1:0]    seg_len,
   output logic [PTR_W-1:0] wr_ptr,
   output logic             done,
   output logic             err
);
   dqb_state_e    state;
   logic          first;
   logic [CW-1:0] seg_left, rest;
   logic [XW-1:0] thr_x, want_x, room_x, n_x, end_x, seg_x;
   logic          due, last_slot;

   always_comb begin
      thr_x     = en ? XW'(HWM) : XW'(1);
      want_x    = en ? XW'(count) : XW'(1);
      room_x    = XW'(room);
      n_x       = (room_x < want_x) ? room_x : want_x;
      end_x     = XW'(size) - XW'(wr_ptr);
      seg_x     = (n_x < end_x) ? n_x : end_x;
      due       = (state == ST_IDLE) && (XW'(count) >= thr_x);
      last_slot = (XW'(addr) + 1'b1) == XW'(size);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         first    <= 1'b0;
         addr     <= '0;
         seg_len  <= '0;
         seg_left <= '0;
         rest     <= '0;
         wr_ptr   <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (state == ST_IDLE) begin
            if (due) begin
               if (room == '0) begin
                  err <= 1'b1;
               end else begin
                  state    <= ST_BURST;
                  addr     <= wr_ptr;
                  seg_len  <= CW'(seg_x);
                  seg_left <= CW'(seg_x);
                  rest     <= CW'(n_x - seg_x);
                  first    <= 1'b1;
               end
            end
         end else begin
            first <= 1'b0;
            if (seg_left == CW'(1)) begin
               wr_ptr <= last_slot ? '0 : addr + 1'b1;
               done   <= 1'b1;
               if (rest != '0) begin
                  addr     <= '0;
                  seg_len  <= rest;
                  seg_left <= rest;
                  rest     <= '0;
                  first    <= 1'b1;
               end else begin
                  state <= ST_IDLE;
               end
            end else begin
               addr     <= addr + 1'b1;
               seg_left <= seg_left - 1'b1;
            end
         end
      end
   end

   assign beat       = (state == ST_BURST);
   assign pop        = beat;
   assign first_beat = beat && first;
endmodule

// File: rtl/dqb_burst_stager.sv
module dqb_burst_stager #(
   parameter int DESC_W = 32,
   parameter int DEPTH  = 8,
   parameter int HWM    = 6,
   parameter int PTR_W  = 10,
   localparam int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              push_valid,
   input  logic [DESC_W-1:0] push_data,
   output logic              push_ready,
   input  logic [PTR_W-1:0]  host_rd_ptr,
   input  logic [PTR_W-1:0]  queue_size,
   output logic              bw_valid,
   output logic              bw_start,
   output logic [PTR_W-1:0]  bw_addr,
   output logic [LEN_W-1:0]  bw_len,
   output logic [DESC_W-1:0] bw_data,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic              wr_done,
   output logic              wr_err
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dqb_burst_stager: DEPTH must be at least 2");
      end
      if (HWM < 1 || HWM > DEPTH) begin : g_bad_hwm
         $error("dqb_burst_stager: HWM must lie in 1..DEPTH");
      end
      if (PTR_W < 2) begin : g_bad_ptr
         $error("dqb_burst_stager: PTR_W must be at least 2");
      end
      if (DESC_W < 1) begin : g_bad_w
         $error("dqb_burst_stager: DESC_W must be positive");
      end
   endgenerate

   logic             full, pop, push;
   logic [LEN_W-1:0] count;
   logic [PTR_W-1:0] room;

   assign push_ready = !full;
   assign push       = push_valid && !full;

   dqb_fifo #(.W(DESC_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (push_data),
      .pop   (pop),
      .dout  (bw_data),
      .count (count),
      .full  (full)
   );

   dqb_room #(.PTR_W(PTR_W)) u_room (
      .wr_idx (wr_ptr),
      .rd_idx (host_rd_ptr),
      .size   (queue_size),
      .room   (room)
   );

   dqb_ctrl #(.DEPTH(DEPTH), .HWM(HWM), .PTR_W(PTR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (fifo_en),
      .count      (count),
      .room       (room),
      .size       (queue_size),
      .pop        (pop),
      .beat       (bw_valid),
      .first_beat (bw_start),
      .addr       (bw_addr),
      .seg_len    (bw_len),
      .wr_ptr     (wr_ptr),
      .done       (wr_done),
      .err        (wr_err)
   );
endmodule

// File: rtl/dqb_burst_stager_chk.sv
module dqb_burst_stager_chk #(
   parameter int PTR_W = 10,
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bw_valid,
   input logic             bw_start,
   input logic [PTR_W-1:0] bw_addr,
   input logic [LEN_W-1:0] bw_len,
   input logic [PTR_W-1:0] wr_ptr,
   input logic             wr_done,
   input logic             wr_err
);
   // R4: an error cycle carries no beat and no commit
   a_r4_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (!bw_valid && !wr_done));

   // R4: the pointer holds across an error
   a_r4_err_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $stable(wr_ptr));

   // R5: the pointer only moves together with a done pulse
   a_r5_ptr_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr != $past(wr_ptr)) |-> wr_done);

   // R9: a start beat carries a nonzero length
   a_r9_start_has_len: assert property (@(posedge clk) disable iff (!rst_n)
      bw_start |-> (bw_valid && bw_len != '0));

   // R9: a non-start beat continues a run from the previous cycle
   a_r9_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && !bw_start) |-> ($past(bw_valid) && bw_addr == $past(bw_addr) + 1'b1));

   // R6: a segment that directly follows another begins at slot zero
   a_r6_split_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_start && $past(bw_valid)) |-> (bw_addr == '0));
endmodule

bind dqb_burst_stager dqb_burst_stager_chk #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bw_valid (bw_valid),
   .bw_start (bw_start),
   .bw_addr  (bw_addr),
   .bw_len   (bw_len),
   .wr_ptr   (wr_ptr),
   .wr_done  (wr_done),
   .wr_err   (wr_err)
);

// File: tb/dqb_burst_stager_tb.sv
`timescale 1ns/1ps
module dqb_burst_stager_tb_top;
   localparam int DESC_W = 32;
   localparam int DEPTH  = 8;
   localparam int HWM    = 6;
   localparam int PTR_W  = 10;
   localparam int LEN_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fifo_en = 1'b1;
   logic              push_valid = 1'b0;
   logic [DESC_W-1:0] push_data = '0;
   logic              push_ready;
   logic [PTR_W-1:0]  host_rd_ptr = '0;
   logic [PTR_W-1:0]  queue_size = PTR_W'(16);
   logic              bw_valid, bw_start, wr_done, wr_err;
   logic [PTR_W-1:0]  bw_addr, wr_ptr;
   logic [LEN_W-1:0]  bw_len;
   logic [DESC_W-1:0] bw_data;

   always #2.5 clk = ~clk;

   dqb_burst_stager #(.DESC_W(DESC_W), .DEPTH(DEPTH), .HWM(HWM), .PTR_W(PTR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
      .push_data(push_data), .push_ready(push_ready), .host_rd_ptr(host_rd_ptr),
      .queue_size(queue_size), .bw_valid(bw_valid), .bw_start(bw_start),
      .bw_addr(bw_addr), .bw_len(bw_len), .bw_data(bw_data), .wr_ptr(wr_ptr),
      .wr_done(wr_done), .wr_err(wr_err)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   bit comparing = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int unsigned q[$];
   bit m_busy, m_first, m_done, m_err;
   int m_addr, m_len, m_left, m_rest, m_wr;

   always @(posedge clk) begin
      int qs, rd, cnt, thr, room, n, seg;
      bit acc;
      if (!rst_n) begin
         q.delete();
         m_busy = 0; m_first = 0; m_done = 0; m_err = 0;
         m_addr = 0; m_len = 0; m_left = 0; m_rest = 0; m_wr = 0;
      end else begin
         qs  = int'(queue_size);
         rd  = int'(host_rd_ptr);
         cnt = q.size();
         acc = push_valid && (cnt < DEPTH);
         m_done = 0; m_err = 0;
         if (m_busy) begin
            void'(q.pop_front());
            m_first = 0;
            m_left--;
            if (m_left == 0) begin
               m_wr   = (m_addr + 1) % qs;
               m_done = 1;
               if (m_rest > 0) begin
                  m_addr = 0; m_len = m_rest; m_left = m_rest; m_rest = 0; m_first = 1;
               end else begin
                  m_busy = 0;
               end
            end else begin
               m_addr++;
            end
         end else begin
            thr = fifo_en ? HWM : 1;
            if (cnt >= thr) begin
               room = (((rd - m_wr - 1) % qs) + qs) % qs;
               if (room == 0) begin
                  m_err = 1;
               end else begin
                  n   = fifo_en ? cnt : 1;
                  if (room < n) n = room;
                  seg = (n < qs - m_wr) ? n : qs - m_wr;
                  m_busy = 1; m_addr = m_wr; m_len = seg; m_left = seg;
                  m_rest = n - seg; m_first = 1;
               end
            end
         end
         if (acc) q.push_back(push_data);
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (comparing && rst_n && !finished) begin
         chk(push_ready == (q.size() < DEPTH), "R8", "push_ready", push_ready, q.size() < DEPTH);
         chk(bw_valid == m_busy, "R2", "bw_valid", bw_valid, m_busy);
         chk(bw_start == (m_busy && m_first), "R9", "bw_start", bw_start, m_busy && m_first);
         chk(int'(wr_ptr) == m_wr, "R5", "wr_ptr", wr_ptr, m_wr);
         chk(wr_done == m_done, "R5", "wr_done", wr_done, m_done);
         chk(wr_err == m_err, "R4", "wr_err", wr_err, m_err);
         if (m_busy) begin
            chk(int'(bw_addr) == m_addr, "R6", "bw_addr", bw_addr, m_addr);
            chk(q.size() > 0 && bw_data == q[0], "R8", "bw_data", bw_data,
                (q.size() > 0) ? q[0] : 0);
            if (m_first)
               chk(int'(bw_len) == m_len, "R3", "bw_len", bw_len, m_len);
         end
         if (!fifo_en && bw_start)
            chk(bw_len == LEN_W'(1), "R7", "bypass bw_len", bw_len, 1);
      end
   end

   // ---------------- stimulus ----------------
   int unsigned next_word = 32'hA000_0000;

   task automatic push_one();
      push_valid = 1'b1;
      push_data  = next_word;
      next_word++;
      while (!push_ready) @(negedge clk);
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic push_n(input int n);
      for (int i = 0; i < n; i++) push_one();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(wr_ptr == '0, "R1", "wr_ptr after reset", wr_ptr, 0);
      chk(!bw_valid && !bw_start, "R1", "beat after reset", bw_valid, 0);
      chk(!wr_done && !wr_err, "R1", "status after reset", {wr_done, wr_err}, 0);
      chk(push_ready, "R1", "push_ready after reset", push_ready, 1);
      comparing = 1;

      // R2: below the mark nothing is written, then a 6-deep burst (R3)
      fifo_en = 1'b1; host_rd_ptr = '0;
      push_n(5);
      idle(4);
      chk(!bw_valid && wr_ptr == '0, "R2", "no write below mark", wr_ptr, 0);
      push_n(1);
      idle(10);
      chk(wr_ptr == PTR_W'(6), "R3", "pointer after full burst", wr_ptr, 6);

      // R3: clipped to room 2, then R4 error while the ring is full
      host_rd_ptr = PTR_W'(9);
      push_n(6);
      idle(6);
      chk(wr_ptr == PTR_W'(8), "R3", "pointer after clipped burst", wr_ptr, 8);
      push_n(2);
      idle(3);
      push_n(2);
      // R8: full FIFO stalls an extra descriptor
      push_valid = 1'b1; push_data = next_word; next_word++;
      idle(3);
      chk(!push_ready, "R8", "ready low when full", push_ready, 0);
      host_rd_ptr = PTR_W'(15);
      while (!push_ready) @(negedge clk);
      @(negedge clk);
      push_valid = 1'b0;
      idle(12);

      // R6: burst crossing the ring end is split
      host_rd_ptr = PTR_W'(7);
      push_n(3);
      idle(14);
      chk(wr_ptr == PTR_W'(4), "R6", "pointer after wrapped burst", wr_ptr, 4);

      // R7: bypass, room for two, then error, then drain
      fifo_en = 1'b0;
      push_n(4);
      idle(6);
      host_rd_ptr = PTR_W'(12);
      idle(12);
      push_n(3);
      idle(10);
      chk(wr_ptr == PTR_W'(11), "R7", "pointer after bypass writes", wr_ptr, 11);

      // back to coalescing with mixed push pressure
      fifo_en = 1'b1; host_rd_ptr = PTR_W'(10);
      push_n(9);
      idle(20);
      finish_run();
   end

   initial begin
      #(5.0 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule